// File: doc/BRIEF.md
# SDRAM Command Bus Protocol Monitor

This block sits on the command side of an SDRAM interface and only listens. On each rising clock edge it decodes the command formed by the chip-select, row strobe, column strobe and write-enable pins. It keeps the open or closed state of each of the four banks, along with a set of per-bank and global interval timers. It then checks every command against the prerequisites and minimum spacings that the memory device requires. Any violation is logged in sticky error state that only reset clears.

The timing limits are parameters given in nanoseconds, together with the clock period. Each limit becomes a clock count by dividing by the period and rounding up. A fixed-window watchdog counts auto refresh commands and flags a window that ends with too few of them. The monitor drives nothing onto the memory bus. It is meant for simulation and for on-chip protocol checking next to a memory controller.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded from {cs_n,ras_n,cas_n,we_n} as follows: 0000 mode set, 0001 refresh, 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge, 0111 no-op. With cs_n high the bus is deselected, and the pins raise no error.
- R2: A command sampled when cke was low at the previous rising edge is ignored.
- R3: The bank index is {ba[1],ba[0]} (0 to 3), and err_bank reports that index. A precharge with a10 high targets all four banks whatever ba holds. A precharge with a10 low touches only the selected bank.
- R4: A mode set while any bank is open raises code 1, and a refresh while any bank is open raises code 2. Both report the lowest-numbered open bank.
- R5: Any command other than no-op or deselect, issued fewer than MRD_CLKS cycles after a mode set, raises code 3.
- R6: A read or write to a closed bank raises code 4. A read or write to an open bank fewer than tRCD cycles after its activate raises code 5.
- R7: A precharge that reaches an open bank fewer than tRAS cycles after that bank's activate raises code 6.
- R8: An activate fewer than tRP cycles after that bank was precharged from the open state raises code 8. An activate fewer than tRC cycles after the previous activate to the same bank raises code 9.
- R9: An activate fewer than tRRD cycles after an activate to a different bank raises code 10.
- R10: An activate to a bank that is already open raises code 7.
- R11: Each limit in clocks is the nanosecond value divided by CLK_NS, rounded up. With CLK_NS=5 and TRCD_NS=18, the limit is 4 cycles.
- R12: The refresh window is a run of REF_WIN_NS worth of clocks starting from reset. A window that ends with fewer than REF_MIN valid refresh commands raises code 11 with bank 0.
- R13: Every raised code sets bit <code> of err_seen, and err_any goes high. err_code and err_bank hold the first error; when several codes fire in one cycle, the lowest code wins. All of this state is sticky until rst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge samples the pins |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select {BA1,BA0} |
| a10 | input | 1 | Address bit 10 (all-bank flag on precharge) |
| err_any | output | 1 | Sticky: at least one error seen |
| err_code | output | 4 | Code of the first error |
| err_bank | output | 2 | Bank of the first error |
| err_seen | output | 16 | Sticky bit per error code |

## Verification
The bench places each timed command exactly on its limit and one cycle short of it. A timer that is off by one, or that truncates instead of rounding up, then either flags the legal case or misses the violation. Several cases check that commands are routed to the right bank. An all-bank precharge issued with a bank field that points elsewhere must still close the other banks and be checked against the other bank's tRAS. A precharge to one bank must leave a different open bank alone, and a design that swapped or ignored bank bits would misreport these. The remaining cases cover the mode-set quiet interval, a command masked by a low clock enable, a deselected bus showing a mode-set pattern, and refresh windows with enough and with too few refreshes. A later error must not overwrite the first code that was recorded.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    localparam int NUM_BANKS = 4;
    localparam int NUM_CODES = 16;

    typedef enum logic [3:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_MRS,
        CMD_REF,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_PRE
    } cmd_e;

    typedef enum logic [3:0] {
        E_NONE     = 4'd0,
        E_MRS_OPEN = 4'd1,
        E_REF_OPEN = 4'd2,
        E_MRD      = 4'd3,
        E_CLOSED   = 4'd4,
        E_TRCD     = 4'd5,
        E_TRAS     = 4'd6,
        E_ACT_OPEN = 4'd7,
        E_TRP      = 4'd8,
        E_TRC      = 4'd9,
        E_TRRD     = 4'd10,
        E_REFRATE  = 4'd11
    } err_e;

    typedef struct packed {
        cmd_e       op;
        logic [1:0] bank;
        logic       all;
    } bus_cmd_t;

    // ceiling division of a time limit by the clock period
    function automatic int ns2clk(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    output bus_cmd_t   cmd_o
);

    logic cke_q;

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b1;
        else     cke_q <= cke;
    end

    always_comb begin
        cmd_o.bank = ba;
        cmd_o.all  = a10;
        if (!cke_q || cs_n) begin
            cmd_o.op = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd_o.op = CMD_MRS;
                3'b001:  cmd_o.op = CMD_REF;
                3'b011:  cmd_o.op = CMD_ACT;
                3'b101:  cmd_o.op = CMD_RD;
                3'b100:  cmd_o.op = CMD_WR;
                3'b110:  cmd_o.op = CMD_BST;
                3'b010:  cmd_o.op = CMD_PRE;
                default: cmd_o.op = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_interval_timer.sv
module sdram_interval_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic elapsed_ok
);

    localparam int W = $clog2(LIMIT + 2);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= W'(LIMIT);
        else if (restart)           cnt <= W'(1);
        else if (cnt < W'(LIMIT))   cnt <= cnt + W'(1);
    end

    assign elapsed_ok = (cnt >= W'(LIMIT));

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
    parameter int RCD_CLKS = 2,
    parameter int RAS_CLKS = 5,
    parameter int RP_CLKS  = 2,
    parameter int RC_CLKS  = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic act_hit,
    input  logic pre_hit,
    output logic is_open,
    output logic rcd_ok,
    output logic ras_ok,
    output logic rp_ok,
    output logic rc_ok
);

    logic open_q;
    logic rp_restart;

    assign rp_restart = pre_hit && open_q;

    always_ff @(posedge clk) begin
        if (rst)          open_q <= 1'b0;
        else if (act_hit) open_q <= 1'b1;
        else if (pre_hit) open_q <= 1'b0;
    end

    assign is_open = open_q;

    sdram_interval_timer #(.LIMIT(RCD_CLKS)) u_rcd (
        .clk(clk), .rst(rst), .restart(act_hit), .elapsed_ok(rcd_ok));
    sdram_interval_timer #(.LIMIT(RAS_CLKS)) u_ras (
        .clk(clk), .rst(rst), .restart(act_hit), .elapsed_ok(ras_ok));
    sdram_interval_timer #(.LIMIT(RC_CLKS)) u_rc (
        .clk(clk), .rst(rst), .restart(act_hit), .elapsed_ok(rc_ok));
    sdram_interval_timer #(.LIMIT(RP_CLKS)) u_rp (
        .clk(clk), .rst(rst), .restart(rp_restart), .elapsed_ok(rp_ok));

endmodule

// File: rtl/sdram_refresh_watch.sv
module sdram_refresh_watch #(
    parameter int WIN_CLKS = 1000,
    parameter int MIN_REFS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_seen,
    output logic short_o
);

    localparam int WW = $clog2(WIN_CLKS + 1);
    localparam int RW = $clog2(MIN_REFS + 2);

    logic [WW-1:0] win_cnt;
    logic [RW-1:0] ref_cnt;
    logic [RW-1:0] ref_total;
    logic          win_end;

    assign win_end   = (win_cnt == WW'(WIN_CLKS - 1));
    assign ref_total = ref_cnt + RW'(ref_seen);
    assign short_o   = win_end && (ref_total < RW'(MIN_REFS));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            ref_cnt <= '0;
        end else if (win_end) begin
            win_cnt <= '0;
            ref_cnt <= '0;
        end else begin
            win_cnt <= win_cnt + WW'(1);
            if (ref_cnt < RW'(MIN_REFS)) ref_cnt <= ref_total;
        end
    end

endmodule

// File: rtl/sdram_err_log.sv
module sdram_err_log
    import sdram_mon_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_CODES-1:0]           hit,
    input  logic [NUM_CODES-1:0][1:0]      hit_bank,
    output logic                           err_any,
    output logic [3:0]                     err_code,
    output logic [1:0]                     err_bank,
    output logic [NUM_CODES-1:0]           err_seen
);

    logic [3:0] pick_code;
    logic [1:0] pick_bank;

    always_comb begin
        pick_code = 4'd0;
        pick_bank = 2'd0;
        for (int i = NUM_CODES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                pick_code = 4'(i);
                pick_bank = hit_bank[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_any  <= 1'b0;
            err_code <= 4'd0;
            err_bank <= 2'd0;
            err_seen <= '0;
        end else begin
            err_seen <= err_seen | hit;
            if (!err_any && (|hit)) begin
                err_any  <= 1'b1;
                err_code <= pick_code;
                err_bank <= pick_bank;
            end
        end
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int TRCD_NS    = 20,
    parameter int TRAS_NS    = 50,
    parameter int TRP_NS     = 20,
    parameter int TRC_NS     = 70,
    parameter int TRRD_NS    = 20,
    parameter int MRD_CLKS   = 2,
    parameter int REF_WIN_NS = 64_000_000,
    parameter int REF_MIN    = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cke,
    input  logic        cs_n,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic [1:0]  ba,
    input  logic        a10,
    output logic        err_any,
    output logic [3:0]  err_code,
    output logic [1:0]  err_bank,
    output logic [15:0] err_seen
);

    localparam int RCD_CLKS = ns2clk(TRCD_NS, CLK_NS);
    localparam int RAS_CLKS = ns2clk(TRAS_NS, CLK_NS);
    localparam int RP_CLKS  = ns2clk(TRP_NS, CLK_NS);
    localparam int RC_CLKS  = ns2clk(TRC_NS, CLK_NS);
    localparam int RRD_CLKS = ns2clk(TRRD_NS, CLK_NS);
    localparam int WIN_CLKS = ns2clk(REF_WIN_NS, CLK_NS);

    bus_cmd_t cmd;

    sdram_cmd_decode u_dec (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd));

    logic [NUM_BANKS-1:0] open_v, rcd_ok, ras_ok, rp_ok, rc_ok;
    logic [NUM_BANKS-1:0] act_v, pre_v;

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        assign act_v[gi] = (cmd.op == CMD_ACT) && (cmd.bank == 2'(gi));
        assign pre_v[gi] = (cmd.op == CMD_PRE) && (cmd.all || cmd.bank == 2'(gi));
        sdram_bank_state #(
            .RCD_CLKS(RCD_CLKS), .RAS_CLKS(RAS_CLKS),
            .RP_CLKS(RP_CLKS),   .RC_CLKS(RC_CLKS)
        ) u_state (
            .clk(clk), .rst(rst), .act_hit(act_v[gi]), .pre_hit(pre_v[gi]),
            .is_open(open_v[gi]), .rcd_ok(rcd_ok[gi]), .ras_ok(ras_ok[gi]),
            .rp_ok(rp_ok[gi]), .rc_ok(rc_ok[gi]));
    end

    logic act_any, rrd_ok, mrd_ok, is_mrs;
    logic [1:0] last_act_bank;

    assign act_any = (cmd.op == CMD_ACT);
    assign is_mrs  = (cmd.op == CMD_MRS);

    sdram_interval_timer #(.LIMIT(RRD_CLKS)) u_rrd (
        .clk(clk), .rst(rst), .restart(act_any), .elapsed_ok(rrd_ok));
    sdram_interval_timer #(.LIMIT(MRD_CLKS)) u_mrd (
        .clk(clk), .rst(rst), .restart(is_mrs), .elapsed_ok(mrd_ok));

    always_ff @(posedge clk) begin
        if (rst)          last_act_bank <= 2'd0;
        else if (act_any) last_act_bank <= cmd.bank;
    end

    logic short_win;

    sdram_refresh_watch #(.WIN_CLKS(WIN_CLKS), .MIN_REFS(REF_MIN)) u_refw (
        .clk(clk), .rst(rst), .ref_seen(cmd.op == CMD_REF), .short_o(short_win));

    logic       any_open;
    logic [1:0] low_open;

    always_comb begin
        any_open = |open_v;
        low_open = 2'd0;
        for (int i = NUM_BANKS - 1; i >= 0; i--)
            if (open_v[i]) low_open = 2'(i);
    end

    logic [NUM_CODES-1:0]      hit;
    logic [NUM_CODES-1:0][1:0] hit_bank;
    logic [1:0]                b;

    assign b = cmd.bank;

    always_comb begin
        hit      = '0;
        hit_bank = '0;

        if (cmd.op != CMD_DESEL && cmd.op != CMD_NOP && !mrd_ok) begin
            hit[E_MRD]      = 1'b1;
            hit_bank[E_MRD] = b;
        end

        unique case (cmd.op)
            CMD_MRS: if (any_open) begin
                hit[E_MRS_OPEN]      = 1'b1;
                hit_bank[E_MRS_OPEN] = low_open;
            end
            CMD_REF: if (any_open) begin
                hit[E_REF_OPEN]      = 1'b1;
                hit_bank[E_REF_OPEN] = low_open;
            end
            CMD_ACT: begin
                if (open_v[b]) begin
                    hit[E_ACT_OPEN]      = 1'b1;
                    hit_bank[E_ACT_OPEN] = b;
                end
                if (!rp_ok[b]) begin
                    hit[E_TRP]      = 1'b1;
                    hit_bank[E_TRP] = b;
                end
                if (!rc_ok[b]) begin
                    hit[E_TRC]      = 1'b1;
                    hit_bank[E_TRC] = b;
                end
                if (!rrd_ok && last_act_bank != b) begin
                    hit[E_TRRD]      = 1'b1;
                    hit_bank[E_TRRD] = b;
                end
            end
            CMD_RD, CMD_WR: begin
                if (!open_v[b]) begin
                    hit[E_CLOSED]      = 1'b1;
                    hit_bank[E_CLOSED] = b;
                end else if (!rcd_ok[b]) begin
                    hit[E_TRCD]      = 1'b1;
                    hit_bank[E_TRCD] = b;
                end
            end
            CMD_PRE: begin
                for (int i = NUM_BANKS - 1; i >= 0; i--) begin
                    if (pre_v[i] && open_v[i] && !ras_ok[i]) begin
                        hit[E_TRAS]      = 1'b1;
                        hit_bank[E_TRAS] = 2'(i);
                    end
                end
            end
            default: ;
        endcase

        if (short_win) begin
            hit[E_REFRATE]      = 1'b1;
            hit_bank[E_REFRATE] = 2'd0;
        end
    end

    sdram_err_log u_log (
        .clk(clk), .rst(rst), .hit(hit), .hit_bank(hit_bank),
        .err_any(err_any), .err_code(err_code), .err_bank(err_bank),
        .err_seen(err_seen));

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
    import sdram_mon_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cke,
    input logic        cs_n,
    input logic        err_any,
    input logic [3:0]  err_code,
    input logic [1:0]  err_bank,
    input logic [15:0] err_seen
);

    localparam logic [15:0] NO_REF_MASK = ~(16'h1 << E_REFRATE);

    // R13
    sticky_any_chk: assert property (@(posedge clk) disable iff (rst)
        err_any |=> err_any);

    // R13
    first_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_any |=> ($stable(err_code) && $stable(err_bank)));

    // R13
    seen_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((err_seen & $past(err_seen)) == $past(err_seen)));

    // R13
    code_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_any) |-> (err_code != 4'd0 && err_seen[err_code]));

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !err_any) |=> (!err_any || err_code == E_REFRATE));

    // R2
    cke_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ##1 ((err_seen & NO_REF_MASK) == ($past(err_seen) & NO_REF_MASK)));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .err_any(err_any),
    .err_code(err_code), .err_bank(err_bank), .err_seen(err_seen));

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;

    // command pin patterns {cs_n,ras_n,cas_n,we_n} (R1)
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_BST = 4'b0110;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DSL = 4'b1000;

    // limits with 5 ns clock: RCD 18->4, RAS 42->9, RP 20->4, RC 70->14, RRD 12->3
    localparam int WIN = 4000;

    typedef struct packed {
        logic [3:0] cmd;
        logic [1:0] bk;
        logic       a10;
        logic [3:0] gap;
    } step_t;

    typedef struct packed {
        step_t      s0;
        step_t      s1;
        step_t      s2;
        step_t      s3;
        logic [3:0] code;
        logic [1:0] bank;
    } vec_t;

    localparam step_t NS = '{C_NOP, 2'd0, 1'b0, 4'd0};

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{'{C_ACT,2'd0,1'b0,4'd2}, '{C_RD,2'd0,1'b0,4'd0}, NS, NS, 4'd5, 2'd0},   // R6 R11
        '{'{C_ACT,2'd0,1'b0,4'd3}, '{C_RD,2'd0,1'b0,4'd0}, NS, NS, 4'd0, 2'd0},   // R6 R11
        '{'{C_RD,2'd1,1'b0,4'd0}, NS, NS, NS, 4'd4, 2'd1},                        // R6
        '{'{C_ACT,2'd0,1'b0,4'd5}, '{C_PRE,2'd0,1'b0,4'd0}, NS, NS, 4'd6, 2'd0},  // R7
        '{'{C_ACT,2'd0,1'b0,4'd8}, '{C_PRE,2'd0,1'b0,4'd0}, NS, NS, 4'd0, 2'd0},  // R7
        '{'{C_ACT,2'd0,1'b0,4'd8}, '{C_PRE,2'd0,1'b0,4'd2}, '{C_ACT,2'd0,1'b0,4'd0}, NS, 4'd8, 2'd0}, // R8
        '{'{C_ACT,2'd0,1'b0,4'd8}, '{C_PRE,2'd0,1'b0,4'd3}, '{C_ACT,2'd0,1'b0,4'd0}, NS, 4'd9, 2'd0}, // R8
        '{'{C_ACT,2'd0,1'b0,4'd8}, '{C_PRE,2'd0,1'b0,4'd4}, '{C_ACT,2'd0,1'b0,4'd0}, NS, 4'd0, 2'd0}, // R8
        '{'{C_ACT,2'd0,1'b0,4'd1}, '{C_ACT,2'd1,1'b0,4'd0}, NS, NS, 4'd10, 2'd1}, // R9
        '{'{C_ACT,2'd0,1'b0,4'd2}, '{C_ACT,2'd3,1'b0,4'd0}, NS, NS, 4'd0, 2'd0},  // R9
        '{'{C_ACT,2'd2,1'b0,4'd0}, '{C_ACT,2'd2,1'b0,4'd0}, NS, NS, 4'd7, 2'd2},  // R10 R13
        '{'{C_ACT,2'd1,1'b0,4'd0}, '{C_MRS,2'd0,1'b0,4'd0}, NS, NS, 4'd1, 2'd1},  // R4
        '{'{C_ACT,2'd1,1'b0,4'd9}, '{C_REF,2'd0,1'b0,4'd0}, NS, NS, 4'd2, 2'd1},  // R4
        '{'{C_MRS,2'd0,1'b0,4'd0}, '{C_ACT,2'd0,1'b0,4'd0}, NS, NS, 4'd3, 2'd0},  // R5
        '{'{C_MRS,2'd0,1'b0,4'd1}, '{C_ACT,2'd0,1'b0,4'd0}, NS, NS, 4'd0, 2'd0},  // R5
        '{'{C_ACT,2'd0,1'b0,4'd3}, '{C_ACT,2'd1,1'b0,4'd8}, '{C_PRE,2'd2,1'b1,4'd3}, '{C_RD,2'd1,1'b0,4'd0}, 4'd4, 2'd1}, // R3
        '{'{C_ACT,2'd3,1'b0,4'd8}, '{C_PRE,2'd0,1'b0,4'd0}, '{C_RD,2'd3,1'b0,4'd0}, NS, 4'd0, 2'd0}, // R3
        '{'{C_ACT,2'd0,1'b0,4'd3}, '{C_WR,2'd0,1'b0,4'd0}, '{C_BST,2'd0,1'b0,4'd0}, '{C_WR,2'd2,1'b0,4'd0}, 4'd4, 2'd2}, // R1 R6
        '{'{C_ACT,2'd0,1'b0,4'd0}, '{C_DSL,2'd0,1'b0,4'd0}, NS, NS, 4'd0, 2'd0},  // R1
        '{'{C_ACT,2'd2,1'b0,4'd2}, '{C_PRE,2'd0,1'b1,4'd0}, NS, NS, 4'd6, 2'd2}   // R3 R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic        a10 = 1'b0;
    logic        err_any;
    logic [3:0]  err_code;
    logic [1:0]  err_bank;
    logic [15:0] err_seen;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sdram_cmd_monitor #(
        .CLK_NS(5), .TRCD_NS(18), .TRAS_NS(42), .TRP_NS(20), .TRC_NS(70),
        .TRRD_NS(12), .MRD_CLKS(2), .REF_WIN_NS(WIN * 5), .REF_MIN(3)
    ) uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .err_any(err_any), .err_code(err_code), .err_bank(err_bank),
        .err_seen(err_seen));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        cke = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] bk, input logic a, input int gap);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba  = bk;
        a10 = a;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        ba  = 2'd0;
        a10 = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic run_step(input step_t s);
        issue(s.cmd, s.bk, s.a10, int'(s.gap));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // reset state (R13)
        do_reset();
        @(negedge clk);
        check(!err_any && err_code == 0 && err_bank == 0 && err_seen == 0,
              "R13 reset state", int'(err_seen), 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            do_reset();
            run_step(VECS[v].s0);
            run_step(VECS[v].s1);
            run_step(VECS[v].s2);
            run_step(VECS[v].s3);
            if (VECS[v].code == 0) begin
                check(!err_any && err_seen == 0,
                      $sformatf("vector %0d R1..R11 expect no error", v), int'(err_code), 0);
            end else begin
                check(err_any && err_code == VECS[v].code,
                      $sformatf("vector %0d code R4..R11", v), int'(err_code), int'(VECS[v].code));
                check(err_bank == VECS[v].bank,
                      $sformatf("vector %0d bank R3", v), int'(err_bank), int'(VECS[v].bank));
                check(err_seen[VECS[v].code],
                      $sformatf("vector %0d seen bit R13", v), int'(err_seen), int'(16'h1 << VECS[v].code));
            end
        end

        // R2: read to closed bank masked by low cke, then the same read counts
        do_reset();
        cke = 1'b0;
        @(negedge clk);
        cke = 1'b1;
        issue(C_RD, 2'd0, 1'b0, 0);
        check(!err_any && err_seen == 0, "R2 masked command ignored", int'(err_code), 0);
        issue(C_RD, 2'd0, 1'b0, 0);
        check(err_any && err_code == 4, "R2 command counted once cke high", int'(err_code), 4);

        // R13: first error held, later errors only add seen bits
        do_reset();
        issue(C_RD, 2'd3, 1'b0, 0);
        issue(C_ACT, 2'd0, 1'b0, 0);
        issue(C_ACT, 2'd0, 1'b0, 0);
        check(err_code == 4 && err_bank == 3, "R13 first code kept", int'(err_code), 4);
        check(err_seen[7] && err_seen[4], "R13 later code recorded", int'(err_seen), 16'h0090);

        // R12: enough refreshes in the first window, too few in the second
        do_reset();
        repeat (3) issue(C_REF, 2'd0, 1'b0, 100);
        repeat (WIN - 303 + 10) @(negedge clk);
        check(!err_any, "R12 window with enough refreshes", int'(err_code), 0);
        repeat (2) issue(C_REF, 2'd0, 1'b0, 100);
        repeat (WIN) @(negedge clk);
        check(err_any && err_code == 11 && err_bank == 0,
              "R12 window short of refreshes", int'(err_code), 11);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule